// File: doc/BRIEF.md
# Interrupt-Driven Peripheral Port

This block sits between a simple processor bus and one slow, byte-wide peripheral. It answers only to its own device address. A write strobe on the bus carries one of four command kinds. Control sends a code to the device. Test reports the status byte and clears the overrun flag. Read fetches one item from the device into an internal data register. Write passes one item from the bus to the device. Control, read and write each run one four-phase request/acknowledge exchange with the device. A parameter sets the minimum number of cycles the request is held, so that a slow device is respected.

When a read exchange finishes, the block raises a level interrupt. It keeps the interrupt up until the processor either acknowledges it on a dedicated line or fetches the data with a read strobe. The block reports BUSY from the moment it accepts a command until the exchange is over. After a read, BUSY stays set until the data has been fetched. A command that arrives while the block is busy is dropped and sets a sticky overrun flag. A fault line from the device is reflected in the status byte.

Top module: `periph_io_unit`

## Requirements
- R1: Commands (bus_wr) and fetches (bus_rd) take effect only when bus_addr equals the DEV_ADDR parameter. At any other address they change neither the device lines, the interrupt nor bus_rdata.
- R2: bus_cmd encodes 00 = control, 01 = test, 10 = read, 11 = write. An accepted control, read or write raises dev_req in the next cycle, with dev_op equal to the command code and dev_wdata equal to bus_wdata as captured with the command. Both stay stable while dev_req is high.
- R3: A test command places the status byte on bus_rdata in the next cycle. The status byte is bit0 READY, bit1 BUSY, bit2 FAULT, bit3 OVERRUN, bit4 IRQ pending, and upper bits 0. After reset it reads 0x01.
- R4: dev_req falls only in the cycle after dev_ack is seen high. A new request is raised only after dev_ack has been seen low again.
- R5: dev_req stays high for at least MIN_LAT cycles, even if dev_ack arrives earlier. With an immediate acknowledge it is high for exactly MIN_LAT cycles.
- R6: On a read, dev_rdata is captured when the acknowledge is accepted. irq rises in the cycle after dev_ack is seen low. irq is low after reset, and control and write exchanges never raise it.
- R7: irq stays high until irq_ack or a fetch at the device address. A fetch returns the data register on bus_rdata in the next cycle and ends BUSY. irq_ack clears irq but leaves BUSY set until the fetch.
- R8: A control, read or write command that arrives while BUSY is set starts no exchange and sets OVERRUN. A test command reports OVERRUN and then clears it.
- R9: FAULT follows dev_fault one cycle later and has no effect on exchanges or on irq.
- R10: A fetch while no read data is pending returns the last captured data and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Command strobe |
| bus_cmd | input | 2 | Command kind |
| bus_wdata | input | DATA_W | Command data or control code |
| bus_rd | input | 1 | Data fetch strobe |
| bus_rdata | output | DATA_W | Fetched data or status byte |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Interrupt acknowledge |
| dev_req | output | 1 | Request to the device |
| dev_op | output | 2 | Operation code sent to the device |
| dev_wdata | output | DATA_W | Data or control code to the device |
| dev_ack | input | 1 | Acknowledge from the device |
| dev_rdata | input | DATA_W | Read data from the device |
| dev_fault | input | 1 | Device fault indication |

## Verification
The properties assume that bus_wr and bus_rd are never high in the same cycle. They also assume a device that keeps dev_ack low until it sees dev_req, and holds dev_ack high until dev_req drops. The bench keeps within these limits. Its device model lives in one process that answers the request after a programmable delay and releases on the request's fall. All bus strobes are driven one at a time from tasks, on the falling clock edge.

// File: rtl/periph_io_pkg.sv
// Shared encodings for the peripheral port: command codes, the link
// sequencer states and the layout of the status byte.
package periph_io_pkg;

    typedef enum logic [1:0] {
        CMD_CTRL  = 2'b00,
        CMD_TEST  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } pio_cmd_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_REQ,
        LK_REL,
        LK_HOLD
    } pio_link_e;

    typedef struct packed {
        logic [2:0] spare;
        logic       irq_pend;
        logic       overrun;
        logic       fault;
        logic       busy;
        logic       ready;
    } pio_status_t;

    localparam int STATUS_W = $bits(pio_status_t);

endpackage

// File: rtl/pio_cmd_decode.sv
// Address recognition and command decoding.
// Assumes: one strobe (bus_wr or bus_rd) per cycle; purely combinational.
module pio_cmd_decode
    import periph_io_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_cmd,
    output logic              start_req,
    output logic              test_req,
    output logic              fetch_req,
    output pio_cmd_e          op
);

    logic hit;

    // Match the bus address and split the strobes into requests.
    always_comb begin
        hit       = (bus_addr == DEV_ADDR);
        op        = pio_cmd_e'(bus_cmd);
        test_req  = bus_wr && hit && (op == CMD_TEST);
        start_req = bus_wr && hit && (op != CMD_TEST);
        fetch_req = bus_rd && hit;
    end

endmodule

// File: rtl/pio_dev_link.sv
// Device-side sequencer: runs one four-phase request/acknowledge
// exchange per accepted command, holds the request at least MIN_LAT
// cycles, captures read data, and waits in HOLD until read data is fetched.
// Assumes: the device keeps ack high until the request falls.
module pio_dev_link
    import periph_io_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  pio_cmd_e          op_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              fetch_req,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_req,
    output logic [1:0]        dev_op,
    output logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              read_done
);

    localparam int CNT_W = (MIN_LAT < 2) ? 1 : $clog2(MIN_LAT + 1);

    pio_link_e         state;
    pio_cmd_e          op_q;
    logic [DATA_W-1:0] wd_q;
    logic              lat_met;

    generate
        if (MIN_LAT <= 1) begin : g_no_lat
            assign lat_met = 1'b1;
        end else begin : g_lat
            logic [CNT_W-1:0] hold_cnt;
            // Count cycles spent with the request high, saturating at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || state != LK_REQ) begin
                    hold_cnt <= CNT_W'(1);
                end else if (!lat_met) begin
                    hold_cnt <= hold_cnt + CNT_W'(1);
                end
            end
            assign lat_met = (hold_cnt >= CNT_W'(MIN_LAT));
        end
    endgenerate

    // Sequence the exchange and capture command and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LK_IDLE;
            op_q   <= CMD_CTRL;
            wd_q   <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                LK_IDLE: if (start_req) begin
                    state <= LK_REQ;
                    op_q  <= op_in;
                    wd_q  <= wdata_in;
                end
                LK_REQ: if (dev_ack && lat_met) begin
                    state <= LK_REL;
                    if (op_q == CMD_READ) data_q <= dev_rdata;
                end
                LK_REL: if (!dev_ack) begin
                    state <= (op_q == CMD_READ) ? LK_HOLD : LK_IDLE;
                end
                LK_HOLD: if (fetch_req) begin
                    state <= LK_IDLE;
                end
                default: state <= LK_IDLE;
            endcase
        end
    end

    // Drive the device lines and the status strobes from the state.
    always_comb begin
        dev_req   = (state == LK_REQ);
        dev_op    = op_q;
        dev_wdata = wd_q;
        busy      = (state != LK_IDLE);
        read_done = (state == LK_REL) && !dev_ack && (op_q == CMD_READ);
    end

endmodule

// File: rtl/pio_status_irq.sv
// Status byte, sticky overrun, fault sampling, interrupt level and the
// registered read-back path.
// Assumes: read_done and fetch_req never coincide (link sequencing).
module pio_status_irq
    import periph_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              test_req,
    input  logic              fetch_req,
    input  logic              irq_ack,
    input  logic              busy,
    input  logic              read_done,
    input  logic [DATA_W-1:0] data_q,
    input  logic              dev_fault,
    output logic              irq,
    output logic [DATA_W-1:0] bus_rdata
);

    pio_status_t status_now;
    logic        overrun;
    logic        fault_q;

    // Assemble the status byte from current state.
    always_comb begin
        status_now          = '0;
        status_now.ready    = !busy;
        status_now.busy     = busy;
        status_now.fault    = fault_q;
        status_now.overrun  = overrun;
        status_now.irq_pend = irq;
    end

    // Keep overrun, fault, interrupt and read-back registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            fault_q   <= 1'b0;
            irq       <= 1'b0;
            bus_rdata <= '0;
        end else begin
            fault_q <= dev_fault;
            if (test_req)               overrun <= 1'b0;
            else if (start_req && busy) overrun <= 1'b1;
            if (read_done)                 irq <= 1'b1;
            else if (irq_ack || fetch_req) irq <= 1'b0;
            if (test_req)       bus_rdata <= DATA_W'(status_now);
            else if (fetch_req) bus_rdata <= data_q;
        end
    end

endmodule

// File: rtl/periph_io_unit.sv
// Interrupt-driven peripheral port: decodes bus commands at one device
// address, runs device exchanges, reports status and raises an interrupt
// when read data is ready.
// Assumes: DATA_W >= 8 so the status byte fits on bus_rdata.
module periph_io_unit
    import periph_io_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5A,
    parameter int                DATA_W   = 8,
    parameter int                MIN_LAT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_cmd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              irq_ack,
    output logic              dev_req,
    output logic [1:0]        dev_op,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_fault
);

    logic              start_req, test_req, fetch_req;
    pio_cmd_e          op;
    logic [DATA_W-1:0] data_q;
    logic              busy, read_done;

    pio_cmd_decode #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_cmd  (bus_cmd),
        .start_req(start_req),
        .test_req (test_req),
        .fetch_req(fetch_req),
        .op       (op)
    );

    pio_dev_link #(.DATA_W(DATA_W), .MIN_LAT(MIN_LAT)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .op_in    (op),
        .wdata_in (bus_wdata),
        .fetch_req(fetch_req),
        .dev_ack  (dev_ack),
        .dev_rdata(dev_rdata),
        .dev_req  (dev_req),
        .dev_op   (dev_op),
        .dev_wdata(dev_wdata),
        .data_q   (data_q),
        .busy     (busy),
        .read_done(read_done)
    );

    pio_status_irq #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .test_req (test_req),
        .fetch_req(fetch_req),
        .irq_ack  (irq_ack),
        .busy     (busy),
        .read_done(read_done),
        .data_q   (data_q),
        .dev_fault(dev_fault),
        .irq      (irq),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/periph_io_unit_chk.sv
// Protocol checker for periph_io_unit, attached by bind.
// Assumes: bus strobes exclusive; device holds ack until request falls.
module periph_io_unit_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5A,
    parameter int                DATA_W   = 8,
    parameter int                MIN_LAT  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [1:0]        bus_cmd,
    input logic              bus_rd,
    input logic              irq,
    input logic              irq_ack,
    input logic              dev_req,
    input logic              dev_ack,
    input logic [DATA_W-1:0] dev_wdata
);

    logic [15:0] req_run;

    // Count consecutive cycles with the request high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !dev_req) req_run <= '0;
        else if (req_run != 16'hFFFF) req_run <= req_run + 16'd1;
    end

    assert_req_on_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_req) |-> $past(bus_wr && bus_addr == DEV_ADDR && bus_cmd != 2'b01));

    assert_wdata_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && $past(dev_req)) |-> $stable(dev_wdata));

    assert_req_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> dev_req);

    assert_req_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_req) |-> $past(dev_ack));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_req) |-> (req_run >= 16'(MIN_LAT)));

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!dev_ack && !dev_req));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !(bus_rd && bus_addr == DEV_ADDR)) |=> irq);

endmodule

bind periph_io_unit periph_io_unit_chk #(
    .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W), .MIN_LAT(MIN_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_cmd(bus_cmd), .bus_rd(bus_rd), .irq(irq), .irq_ack(irq_ack),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata)
);

// File: tb/periph_io_unit_test.sv
module periph_io_unit_test;

    localparam int       AW   = 8;
    localparam int       DW   = 8;
    localparam int       LAT  = 4;
    localparam [AW-1:0]  ME   = 8'h5A;
    localparam [1:0] C_CTRL = 2'b00, C_TEST = 2'b01, C_READ = 2'b10, C_WRITE = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0, dev_fault = 1'b0;
    logic [1:0] bus_cmd = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata, dev_wdata;
    logic [DW-1:0] dev_rdata = '0;
    logic irq, dev_req, dev_ack = 1'b0;
    logic [1:0] dev_op;

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    periph_io_unit #(.ADDR_W(AW), .DEV_ADDR(ME), .DATA_W(DW), .MIN_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
        .dev_req(dev_req), .dev_op(dev_op), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_fault(dev_fault)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Device model: acknowledge after dev_dly cycles of request, release on its fall.
    int dev_dly = 2, hi = 0, run = 0, last_run = 0;
    logic [1:0] last_op = '0;
    logic [DW-1:0] last_wd = '0;
    always @(negedge clk) begin
        if (dev_req) begin
            run <= run + 1;
            if (!dev_ack && hi >= dev_dly) begin
                dev_ack <= 1'b1;
                last_op <= dev_op;
                last_wd <= dev_wdata;
            end
            hi <= hi + 1;
        end else begin
            if (run != 0) last_run <= run;
            run <= 0;
            hi <= 0;
            dev_ack <= 1'b0;
        end
    end

    // Behavioural reference: phase 0 idle, 1 request, 2 release, 3 holding data.
    int m_ph = 0, m_cnt = 1;
    logic [1:0] m_op = '0;
    logic [DW-1:0] m_data = '0, m_rdata = '0;
    bit m_irq = 0, m_ovr = 0, m_flt = 0;
    always @(posedge clk) begin
        bit hitw, hitr, setirq;
        logic [7:0] st;
        logic [DW-1:0] old_data;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 1; m_op = '0; m_data = '0; m_rdata = '0;
            m_irq = 0; m_ovr = 0; m_flt = 0;
        end else begin
            hitw = bus_wr && bus_addr == ME;
            hitr = bus_rd && bus_addr == ME;
            st = {3'b0, m_irq, m_ovr, m_flt, m_ph != 0, m_ph == 0};
            old_data = m_data;
            setirq = 0;
            if (hitw && bus_cmd == C_TEST) begin m_rdata = st; m_ovr = 0; end
            else if (hitw && m_ph != 0) m_ovr = 1;
            if (hitr) m_rdata = old_data;
            case (m_ph)
                0: if (hitw && bus_cmd != C_TEST) begin m_ph = 1; m_cnt = 1; m_op = bus_cmd; end
                1: if (dev_ack && m_cnt >= LAT) begin
                       if (m_op == C_READ) m_data = dev_rdata;
                       m_ph = 2;
                   end else if (m_cnt < LAT) m_cnt++;
                2: if (!dev_ack) begin
                       m_ph = (m_op == C_READ) ? 3 : 0;
                       setirq = (m_op == C_READ);
                   end
                default: if (hitr) m_ph = 0;
            endcase
            if (setirq) m_irq = 1;
            else if (irq_ack || hitr) m_irq = 0;
            m_flt = dev_fault;
        end
    end

    // Compare against the reference on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(dev_req == (m_ph == 1), "R4 dev_req per-cycle", dev_req, m_ph == 1);
            chk(irq == m_irq, "R6 irq per-cycle", irq, m_irq);
            chk(bus_rdata == m_rdata, "R7 bus_rdata per-cycle", bus_rdata, m_rdata);
        end
    end

    task automatic cmd(input [AW-1:0] a, input [1:0] c, input [DW-1:0] d);
        bus_addr = a; bus_cmd = c; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic fetch(input [AW-1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && m_ph != 0 && m_ph != 3; i++) @(negedge clk);
    endtask

    task automatic status_is(input [7:0] exp, input string tag);
        cmd(ME, C_TEST, '0);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(irq == 0 && dev_req == 0, "R6 reset irq/req low", {irq, dev_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        status_is(8'h01, "R3 reset status");

        // R2 write exchange carries code and data
        cmd(ME, C_WRITE, 8'hA5);
        chk(dev_req == 1 && dev_op == C_WRITE && dev_wdata == 8'hA5, "R2 write request",
            {dev_req, dev_op, dev_wdata}, {1'b1, C_WRITE, 8'hA5});
        status_is(8'h02, "R3 busy during exchange");
        cmd(ME, C_READ, 8'h00);   // dropped: busy
        wait_idle(); @(negedge clk);
        chk(last_op == C_WRITE && last_wd == 8'hA5, "R2 device saw write", last_wd, 8'hA5);
        chk(irq == 0, "R6 no irq after write", irq, 0);
        status_is(8'h09, "R8 overrun reported");
        status_is(8'h01, "R8 overrun cleared by test");

        // R1 foreign address ignored
        cmd(8'h11, C_WRITE, 8'h77);
        for (int i = 0; i < 4; i++) begin
            chk(dev_req == 0, "R1 no request for foreign address", dev_req, 0);
            @(negedge clk);
        end
        cmd(8'h11, C_TEST, '0);
        chk(bus_rdata == 8'h01, "R1 foreign test leaves rdata", bus_rdata, 8'h01);

        // R6/R7 read with fetch
        dev_rdata = 8'h3C;
        cmd(ME, C_READ, '0);
        wait_idle(); @(negedge clk);
        chk(irq == 1, "R6 irq after read", irq, 1);
        repeat (3) @(negedge clk);
        chk(irq == 1, "R7 irq held", irq, 1);
        status_is(8'h12, "R7 status while data pending");
        fetch(8'h22);
        chk(irq == 1, "R1 foreign fetch ignored", irq, 1);
        fetch(ME);
        chk(bus_rdata == 8'h3C && irq == 0, "R7 fetch returns data", bus_rdata, 8'h3C);
        status_is(8'h01, "R7 ready after fetch");

        // R7 acknowledge then fetch
        dev_rdata = 8'hC7;
        cmd(ME, C_READ, '0);
        wait_idle(); @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(irq == 0, "R7 irq_ack clears irq", irq, 0);
        status_is(8'h02, "R7 still busy after ack");
        fetch(ME);
        chk(bus_rdata == 8'hC7, "R7 fetch after ack", bus_rdata, 8'hC7);

        // R10 idle fetch returns last data
        dev_rdata = 8'h00;
        fetch(ME);
        chk(bus_rdata == 8'hC7, "R10 idle fetch data", bus_rdata, 8'hC7);
        status_is(8'h01, "R10 idle fetch leaves status");

        // R5 minimum request length with immediate acknowledge
        dev_dly = 0;
        cmd(ME, C_CTRL, 8'h3E);
        wait_idle(); @(negedge clk); @(negedge clk);
        chk(last_run == LAT, "R5 request length", last_run, LAT);
        chk(last_op == C_CTRL && last_wd == 8'h3E, "R2 control code", last_wd, 8'h3E);
        dev_dly = 7;
        cmd(ME, C_WRITE, 8'h5F);
        wait_idle(); @(negedge clk); @(negedge clk);
        chk(last_run >= LAT, "R5 slow device request length", last_run, LAT);

        // R9 fault reporting
        dev_fault = 1'b1;
        @(negedge clk);
        status_is(8'h05, "R9 fault bit");
        cmd(ME, C_WRITE, 8'h12);
        chk(dev_req == 1, "R9 fault does not block", dev_req, 1);
        wait_idle();
        dev_fault = 1'b0;
        @(negedge clk);
        status_is(8'h01, "R9 fault cleared");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule